// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides whether an arriving Ethernet frame should be kept, judging only by its 48-bit destination address. Software programs the filter by streaming a 192-byte station-address image into it one byte per valid cycle. The image holds sixteen 12-byte slots. Each slot carries one address spread over its first ten bytes. The loader pulls out the six address bytes, drops any slot that holds a group address, and packs the remaining unicast addresses into a table of up to sixteen entries.

A lookup presents a destination address together with the promiscuous control bit. Two cycles later the block returns a one-cycle result strobe and an accept flag. Promiscuous lookups and group destinations (multicast or broadcast) are always accepted. A unicast destination is accepted only if it equals a stored entry.

The table is double-buffered. Lookups made while a load is in progress see the previous table. The new table takes effect on the edge that consumes the end-marked byte.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset, `res_valid` is low, and the table is empty, so a unicast lookup without promiscuous mode is rejected.
- R2: Every cycle with `req_valid` high produces exactly one cycle of `res_valid` two clock edges later. `res_valid` is never high otherwise.
- R3: A lookup made with `promisc_en` high is accepted whatever its address.
- R4: A lookup whose address has the group bit set is accepted. The group bit is `req_addr[40]`, the least significant bit of the first transmitted byte `req_addr[47:40]`.
- R5: Without promiscuous mode, a unicast lookup is accepted only if the address equals a committed table entry. A unicast address that differs from every committed entry in any single bit is rejected.
- R6: Address byte k (k = 0 to 5, byte 0 placed in `req_addr[47:40]`) is taken from slot offset 0, 1, 4, 5, 8 or 9 respectively. Slot offsets 2, 3, 6, 7, 10 and 11 have no effect on the table.
- R7: A slot whose first address byte has bit 0 set is not stored. The unicast slots of one image are packed in slot order, and all sixteen can be held at once.
- R8: A byte with `setup_start` high is slot 0, offset 0 of a fresh image. Entries committed by an earlier load stop matching once the fresh load commits, unless the fresh image also holds them.
- R9: During a load, lookups use the previously committed table. This includes a lookup made in the same cycle as the end-marked byte. The new table is used by lookups made after that byte.
- R10: Valid bytes arriving before any `setup_start` are ignored, and so is their end marker. Bytes beyond the 192nd of an image are ignored. An end marker on such a late byte still commits the image.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| setup_valid | input | 1 | Setup byte valid |
| setup_byte | input | 8 | Setup image byte |
| setup_start | input | 1 | Marks the first byte of an image (qualified by valid) |
| setup_end | input | 1 | Marks the last byte of an image (qualified by valid) |
| promisc_en | input | 1 | Promiscuous mode, sampled with the request |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | 48 | Destination address, first byte in bits 47:40 |
| res_valid | output | 1 | Result strobe, two edges after the request |
| res_accept | output | 1 | Accept (1) or reject (1'b0) for the strobed result |

## Verification
The bench loads several images and sweeps lookups across them:
- **Mixed image.** Half the slots hold group addresses and the junk offsets carry distinct filler. This separates correct byte extraction and skipping from a loader that takes the wrong offsets or stores group slots.
- **Single-bit flips.** Each of the 48 bits of a stored entry is flipped in turn. This exposes a comparator that ignores any address bit.
- **Promiscuous and group queries.** These are aimed at addresses known to be absent, so they can only pass through the bypass paths.
- **Mid-load and end-cycle lookups.** These tell a double-buffered commit apart from in-place writing.
- **Stray and overlong streams.** Bytes sent without a start, and an image padded past 192 bytes, check that such bytes leave the table alone.

// File: rtl/raf_pkg.sv
package raf_pkg;

  localparam int MAC_W = 48;

  typedef logic [MAC_W-1:0] mac_t;

  // Map a slot byte offset to the address byte it carries; 7 means unused.
  function automatic logic [2:0] slot_lane(input logic [3:0] off);
    logic [2:0] lane;
    if (off[1] || (off > 4'd9)) begin
      lane = 3'd7;
    end else begin
      lane = {off[3:2], 1'b0} + {2'b00, off[0]};
    end
    return lane;
  endfunction

endpackage

// File: rtl/raf_setup_loader.sv
module raf_setup_loader
  import raf_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int SLOT_BYTES  = 12,
  localparam int IDX_W = $clog2(NUM_ENTRIES),
  localparam int CNT_W = $clog2(NUM_ENTRIES + 1),
  localparam int OFF_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_byte,
  input  logic             in_start,
  input  logic             in_end,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output mac_t             wr_addr,
  output logic             commit,
  output logic [CNT_W-1:0] commit_cnt
);

  logic             loading_q, loading_nxt;
  logic             full_q,    full_nxt;
  logic [OFF_W-1:0] off_q,     off_nxt;
  logic [IDX_W-1:0] slot_q,    slot_nxt;
  logic [CNT_W-1:0] cnt_q,     cnt_nxt;
  logic [39:0]      asm_q,     asm_nxt;

  logic             take, start_c, full_c, capture;
  logic [OFF_W-1:0] off_c;
  logic [IDX_W-1:0] slot_c;
  logic [CNT_W-1:0] cnt_c;
  logic [2:0]       lane;

  always_comb begin
    start_c     = in_valid && in_start;
    take        = in_valid && (in_start || loading_q);
    off_c       = start_c ? '0 : off_q;
    slot_c      = start_c ? '0 : slot_q;
    cnt_c       = start_c ? '0 : cnt_q;
    full_c      = start_c ? 1'b0 : full_q;
    capture     = take && !full_c;
    lane        = slot_lane(off_c);

    asm_nxt     = asm_q;
    wr_en       = 1'b0;
    wr_idx      = cnt_c[IDX_W-1:0];
    wr_addr     = {asm_q, in_byte};
    off_nxt     = off_c;
    slot_nxt    = slot_c;
    full_nxt    = full_c;

    if (capture) begin
      case (lane)
        3'd0: asm_nxt[39:32] = in_byte;
        3'd1: asm_nxt[31:24] = in_byte;
        3'd2: asm_nxt[23:16] = in_byte;
        3'd3: asm_nxt[15:8]  = in_byte;
        3'd4: asm_nxt[7:0]   = in_byte;
        3'd5: wr_en = !asm_q[32] && (cnt_c < CNT_W'(NUM_ENTRIES));
        default: ;
      endcase
      if (off_c == OFF_W'(SLOT_BYTES - 1)) begin
        off_nxt = '0;
        if (slot_c == IDX_W'(NUM_ENTRIES - 1)) begin
          full_nxt = 1'b1;
        end else begin
          slot_nxt = slot_c + 1'b1;
        end
      end else begin
        off_nxt = off_c + 1'b1;
      end
    end

    cnt_nxt     = cnt_c + CNT_W'(wr_en);
    loading_nxt = !in_end;
    commit      = take && in_end;
    commit_cnt  = cnt_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loading_q <= 1'b0;
      full_q    <= 1'b0;
      off_q     <= '0;
      slot_q    <= '0;
      cnt_q     <= '0;
      asm_q     <= '0;
    end else if (take) begin
      loading_q <= loading_nxt;
      full_q    <= full_nxt;
      off_q     <= off_nxt;
      slot_q    <= slot_nxt;
      cnt_q     <= cnt_nxt;
      asm_q     <= asm_nxt;
    end
  end

  // R7
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(NUM_ENTRIES));

  // R8
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_start) |=> (cnt_q == '0));

endmodule

// File: rtl/raf_table.sv
module raf_table
  import raf_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  localparam int IDX_W = $clog2(NUM_ENTRIES),
  localparam int CNT_W = $clog2(NUM_ENTRIES + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       wr_idx,
  input  mac_t                   wr_addr,
  input  logic                   commit,
  input  logic [CNT_W-1:0]       commit_cnt,
  input  mac_t                   look_addr,
  output logic [NUM_ENTRIES-1:0] hit_vec
);

  logic             sel_q, sel_nxt;
  logic [CNT_W-1:0] act_cnt_q, act_cnt_nxt;

  always_comb begin
    sel_nxt     = sel_q;
    act_cnt_nxt = act_cnt_q;
    if (commit) begin
      sel_nxt     = !sel_q;
      act_cnt_nxt = commit_cnt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q     <= 1'b0;
      act_cnt_q <= '0;
    end else begin
      sel_q     <= sel_nxt;
      act_cnt_q <= act_cnt_nxt;
    end
  end

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
    mac_t b0_q, b1_q;
    logic sel_wr;
    mac_t act_e;

    assign sel_wr = wr_en && (wr_idx == IDX_W'(g));

    // Writes always land in the bank that is not being looked up.
    always_ff @(posedge clk) begin
      if (sel_wr && sel_q) begin
        b0_q <= wr_addr;
      end
    end

    always_ff @(posedge clk) begin
      if (sel_wr && !sel_q) begin
        b1_q <= wr_addr;
      end
    end

    assign act_e      = sel_q ? b1_q : b0_q;
    assign hit_vec[g] = (CNT_W'(g) < act_cnt_q) && (act_e == look_addr);
  end

  // R9
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(sel_q) && $stable(act_cnt_q));

  // R9
  commit_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (act_cnt_q == $past(commit_cnt)));

endmodule

// File: rtl/raf_match.sv
module raf_match
  import raf_pkg::*;
#(
  parameter int NUM_ENTRIES = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  mac_t                   req_addr,
  input  logic                   promisc,
  input  logic [NUM_ENTRIES-1:0] hit_vec,
  output logic                   res_valid,
  output logic                   res_accept
);

  logic                   s1_valid_q, s1_bypass_q;
  logic [NUM_ENTRIES-1:0] s1_hits_q;
  logic                   s1_bypass_nxt, accept_nxt;

  always_comb begin
    s1_bypass_nxt = promisc || req_addr[40];
    accept_nxt    = s1_bypass_q || (|s1_hits_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid_q  <= 1'b0;
      s1_bypass_q <= 1'b0;
      s1_hits_q   <= '0;
      res_valid   <= 1'b0;
      res_accept  <= 1'b0;
    end else begin
      s1_valid_q <= req_valid;
      res_valid  <= s1_valid_q;
      if (req_valid) begin
        s1_bypass_q <= s1_bypass_nxt;
        s1_hits_q   <= hit_vec;
      end
      if (s1_valid_q) begin
        res_accept <= accept_nxt;
      end
    end
  end

  // R2
  res_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(req_valid, 2));

  // R3
  promisc_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $past(promisc, 2)) |-> res_accept);

  // R4
  group_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $past(req_addr[40], 2)) |-> res_accept);

  // R5
  reject_needs_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_accept) |-> ($past(hit_vec, 2) == '0));

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import raf_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int SLOT_BYTES  = 12,
  localparam int IDX_W = $clog2(NUM_ENTRIES),
  localparam int CNT_W = $clog2(NUM_ENTRIES + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        setup_valid,
  input  logic [7:0]  setup_byte,
  input  logic        setup_start,
  input  logic        setup_end,
  input  logic        promisc_en,
  input  logic        req_valid,
  input  logic [47:0] req_addr,
  output logic        res_valid,
  output logic        res_accept
);

  logic [1:0]             rst_sync_q;
  logic                   rst_int_n;
  logic                   wr_en, commit;
  logic [IDX_W-1:0]       wr_idx;
  mac_t                   wr_addr;
  logic [CNT_W-1:0]       commit_cnt;
  logic [NUM_ENTRIES-1:0] hit_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_int_n = rst_sync_q[1];

  raf_setup_loader #(.NUM_ENTRIES(NUM_ENTRIES), .SLOT_BYTES(SLOT_BYTES)) u_loader (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .in_valid   (setup_valid),
    .in_byte    (setup_byte),
    .in_start   (setup_start),
    .in_end     (setup_end),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_addr    (wr_addr),
    .commit     (commit),
    .commit_cnt (commit_cnt)
  );

  raf_table #(.NUM_ENTRIES(NUM_ENTRIES)) u_table (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_addr    (wr_addr),
    .commit     (commit),
    .commit_cnt (commit_cnt),
    .look_addr  (req_addr),
    .hit_vec    (hit_vec)
  );

  raf_match #(.NUM_ENTRIES(NUM_ENTRIES)) u_match (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .promisc    (promisc_en),
    .hit_vec    (hit_vec),
    .res_valid  (res_valid),
    .res_accept (res_accept)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_int_n |=> !res_valid);

endmodule

// File: tb/rx_addr_filter_tb_top.sv
module rx_addr_filter_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        setup_valid, setup_start, setup_end;
  logic [7:0]  setup_byte;
  logic        promisc_en, req_valid;
  logic [47:0] req_addr;
  logic        res_valid, res_accept;

  int n_checks = 0;
  int n_fail   = 0;

  logic [47:0] img_addr [16];
  logic [47:0] exp_tab  [16];
  int          exp_n    = 0;

  always #4 clk = ~clk;

  rx_addr_filter dut_i (
    .clk(clk), .rst_n(rst_n),
    .setup_valid(setup_valid), .setup_byte(setup_byte),
    .setup_start(setup_start), .setup_end(setup_end),
    .promisc_en(promisc_en), .req_valid(req_valid), .req_addr(req_addr),
    .res_valid(res_valid), .res_accept(res_accept)
  );

  task automatic check(input logic ok, input string tag, input logic [47:0] act, input logic [47:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [47:0] mk_addr(input int seed, input int i, input logic grp);
    logic [7:0] b0;
    b0 = 8'(seed * 16 + i * 2) | {7'd0, grp};
    return {b0, 8'(i), 8'(8'h10 + seed), 8'(8'h20 + i), 8'(seed), 8'(i * 3 + 1)};
  endfunction

  // Byte at offset off of slot s of the image held in img_addr (R6 layout).
  function automatic logic [7:0] img_byte(input int s, input int off);
    logic [47:0] a;
    a = img_addr[s];
    case (off)
      0: return a[47:40];
      1: return a[39:32];
      4: return a[31:24];
      5: return a[23:16];
      8: return a[15:8];
      9: return a[7:0];
      default: return 8'(s * 13 + off * 7 + 8'h5A);
    endcase
  endfunction

  function automatic logic in_tab(input logic [47:0] a);
    for (int k = 0; k < exp_n; k++) if (exp_tab[k] == a) return 1'b1;
    return 1'b0;
  endfunction

  task automatic build_model();
    exp_n = 0;
    for (int s = 0; s < 16; s++) begin
      if (!img_addr[s][40]) begin
        exp_tab[exp_n] = img_addr[s];
        exp_n++;
      end
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input logic s, input logic e);
    @(negedge clk);
    setup_valid = 1'b1; setup_byte = b; setup_start = s; setup_end = e;
    @(negedge clk);
    setup_valid = 1'b0; setup_start = 1'b0; setup_end = 1'b0;
  endtask

  task automatic send_range(input int from, input int to, input logic end_last);
    for (int n = from; n <= to; n++)
      send_byte(img_byte(n / 12, n % 12), n == 0, end_last && (n == to));
  endtask

  task automatic lookup(input logic [47:0] a, input logic p, input string tag);
    logic exp;
    exp = p | a[40] | in_tab(a);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; promisc_en = p;
    @(negedge clk);
    req_valid = 1'b0; promisc_en = 1'b0;
    check(res_valid == 1'b0, "R2 early strobe", 48'(res_valid), 48'd0);
    @(negedge clk);
    check(res_valid == 1'b1, "R2 strobe", 48'(res_valid), 48'd1);
    check(res_accept == exp, tag, 48'(res_accept), 48'(exp));
    @(negedge clk);
    check(res_valid == 1'b0, "R2 single strobe", 48'(res_valid), 48'd0);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; setup_valid = 1'b0; setup_byte = 8'h00; setup_start = 1'b0;
    setup_end = 1'b0; promisc_en = 1'b0; req_valid = 1'b0; req_addr = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: quiet outputs and empty table after reset
    check(res_valid == 1'b0, "R1 res_valid", 48'(res_valid), 48'd0);
    lookup(mk_addr(1, 0, 1'b0), 1'b0, "R1 empty reject");
    lookup(48'h0, 1'b0, "R1 zero reject");

    // Image A: odd slots are group addresses (R6, R7)
    for (int s = 0; s < 16; s++) img_addr[s] = mk_addr(1, s, 1'(s % 2));
    send_range(0, 191, 1'b1);
    build_model();
    for (int s = 0; s < 16; s++) lookup(img_addr[s], 1'b0, "R7 image A slot");
    for (int s = 1; s < 16; s += 2) lookup(img_addr[s] & ~48'h0100_0000_0000, 1'b0, "R7 group slot not stored");
    for (int s = 0; s < 4; s++)
      lookup({img_byte(s, 2) & 8'hFE, img_byte(s, 3), img_byte(s, 6),
              img_byte(s, 7), img_byte(s, 10), img_byte(s, 11)}, 1'b0, "R6 ignored offsets");
    for (int b = 0; b < 48; b++) lookup(img_addr[2] ^ (48'd1 << b), 1'b0, "R5 single bit flip");
    for (int s = 0; s < 8; s++) lookup(mk_addr(9, s, 1'b1), 1'b0, "R4 group accept");
    for (int s = 0; s < 8; s++) lookup(mk_addr(9, s, 1'b0), 1'b1, "R3 promiscuous accept");
    lookup(48'hFFFF_FFFF_FFFF, 1'b0, "R4 broadcast accept");

    // Image B: all sixteen unicast (R7 capacity, R8 replacement)
    for (int s = 0; s < 16; s++) img_addr[s] = mk_addr(2, s, 1'b0);
    send_range(0, 191, 1'b1);
    build_model();
    for (int s = 0; s < 16; s++) lookup(img_addr[s], 1'b0, "R7 full table accept");
    for (int s = 0; s < 16; s += 2) lookup(mk_addr(1, s, 1'b0), 1'b0, "R8 old entries dropped");

    // Image C, with lookups mid-load and on the end cycle (R9)
    for (int s = 0; s < 16; s++) img_addr[s] = mk_addr(3, s, 1'(s == 5));
    send_range(0, 99, 1'b0);
    lookup(mk_addr(2, 3, 1'b0), 1'b0, "R9 old table during load");
    lookup(mk_addr(3, 0, 1'b0), 1'b0, "R9 new entry not yet visible");
    send_range(100, 190, 1'b0);
    @(negedge clk);
    setup_valid = 1'b1; setup_byte = img_byte(15, 11); setup_end = 1'b1;
    req_valid = 1'b1; req_addr = mk_addr(2, 7, 1'b0);
    @(negedge clk);
    setup_valid = 1'b0; setup_end = 1'b0; req_valid = 1'b0;
    @(negedge clk);
    check(res_valid == 1'b1, "R9 end-cycle strobe", 48'(res_valid), 48'd1);
    check(res_accept == 1'b1, "R9 end-cycle uses old table", 48'(res_accept), 48'd1);
    @(negedge clk);
    build_model();
    for (int s = 0; s < 16; s++) lookup(img_addr[s], 1'b0, "R9 new table visible");
    for (int s = 0; s < 16; s += 3) lookup(mk_addr(2, s, 1'b0), 1'b0, "R8 previous table gone");

    // Stray bytes without a start (R10)
    for (int s = 0; s < 16; s++) img_addr[s] = mk_addr(4, s, 1'b0);
    for (int n = 0; n < 24; n++) send_byte(img_byte(n / 12, n % 12), 1'b0, n == 23);
    for (int s = 0; s < 16; s++) img_addr[s] = mk_addr(3, s, 1'(s == 5));
    lookup(mk_addr(4, 0, 1'b0), 1'b0, "R10 stray bytes ignored");
    lookup(mk_addr(4, 1, 1'b0), 1'b0, "R10 stray bytes ignored");
    lookup(mk_addr(3, 2, 1'b0), 1'b0, "R10 table kept");

    // Overlong image: 192 bytes plus one extra slot, end on the last extra (R10)
    for (int s = 0; s < 16; s++) img_addr[s] = mk_addr(5, s, 1'(s > 11));
    send_range(0, 191, 1'b0);
    build_model();
    for (int s = 0; s < 16; s++) img_addr[s] = mk_addr(6, s, 1'b0);
    for (int n = 0; n < 12; n++) send_byte(img_byte(0, n), 1'b0, n == 11);
    lookup(mk_addr(6, 0, 1'b0), 1'b0, "R10 overrun slot ignored");
    for (int s = 0; s < 16; s++) lookup(mk_addr(5, s, 1'(s > 11)), 1'b0, "R10 overrun image committed");
    lookup(mk_addr(3, 0, 1'b0), 1'b0, "R8 replaced by overrun image");

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule